// File: doc/BRIEF.md
# Dual-Issue Instruction Dispatch Unit

This block keeps decoded instructions in a six-slot, in-order queue. Every cycle it decides how many of the two oldest slots can be handed to the execution units. A slot may issue only when four conditions hold:

- its target unit is idle;
- no other instruction goes to that unit in the same cycle;
- enough rename registers are free for its destination operands;
- the completion queue has room for it.

Instructions that issue leave the queue. The survivors slide down toward slot 0, and a new fetched instruction is written behind them if a slot is left.

The surrounding pipeline feeds one decoded instruction per cycle through a push port. The push carries a tag, the index of the target execution unit and the number of destination operands. The pipeline also reports, as plain inputs, the unit busy flags, the count of free rename registers and the count of free completion-queue slots. The block answers with:

- which slots issued and their tags;
- one strobe per execution unit;
- the number of rename registers and completion slots taken;
- the queue occupancy.

A flush input empties the queue.

Top module: `iq_dispatch_top`

## Requirements
- R1: After reset the queue is empty (`queueCount` = 0) and neither `dispGo0` nor `dispGo1` is asserted.
- R2: Only the two oldest slots can issue. Slot 1 issues only in a cycle where slot 0 also issues, so `dispGo1` implies `dispGo0`.
- R3: An instruction whose target unit has its `unitBusy` bit set does not issue.
- R4: Two instructions in slots 0 and 1 naming the same unit cannot both issue. At most one strobe per unit is raised per cycle, and the number of raised strobes equals `cqAlloc`.
- R5: Slot 0 needs `renameFree` >= its destination count. Issuing both slots needs `renameFree` >= the sum of both counts. `renameAlloc` reports the sum for the issued slots, so an instruction with zero destinations issues even when `renameFree` is 0.
- R6: Slot 0 needs `cqFree` >= 1 and issuing both needs `cqFree` >= 2. With `cqFree` = 0 nothing issues. `cqAlloc` equals the number issued.
- R7: On the clock edge after a cycle that issues N instructions (N = 0, 1 or 2), the remaining entries move down by N, keeping their order. Without a push, `queueCount` drops by N.
- R8: A push is accepted (`pushAccept` high) only when `queueCount` minus the number issued in the same cycle is below 6. An accepted push lands behind the survivors and raises `queueCount` by one. A refused push is dropped.
- R9: While `flush` is high nothing issues and no push is accepted. On the next edge `queueCount` becomes 0.
- R10: `pushUnit` is a 2-bit binary unit index, and an issue to unit k raises bit k of `dispStrobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the queue and blocks issue and push |
| pushValid | input | 1 | A fetched instruction is offered |
| pushTag | input | 8 | Tag of the offered instruction |
| pushUnit | input | 2 | Target execution-unit index |
| pushDests | input | 2 | Number of destination operands |
| pushAccept | output | 1 | Offered instruction is taken this cycle |
| unitBusy | input | 4 | One busy flag per execution unit |
| renameFree | input | 4 | Free rename registers |
| cqFree | input | 3 | Free completion-queue slots |
| dispGo0 | output | 1 | Slot 0 issues this cycle |
| dispTag0 | output | 8 | Tag in slot 0 |
| dispGo1 | output | 1 | Slot 1 issues this cycle |
| dispTag1 | output | 8 | Tag in slot 1 |
| dispStrobe | output | 4 | Per-unit issue strobes |
| renameAlloc | output | 4 | Rename registers taken this cycle |
| cqAlloc | output | 2 | Completion-queue slots taken this cycle |
| queueCount | output | 3 | Occupied queue slots |

## Verification
The bench targets cases where slot 1 could issue on its own merits but must not:

- slot 0 is blocked by a busy unit;
- the rename supply covers either instruction alone but not both;
- only one completion slot is free;
- both slots name the same unit.

A design that checked the slots independently would issue out of order or double-book a unit in these cases. Each case has its own check.

It also pushes into a full queue in the same cycle as an issue. A design that tested fullness before subtracting the issued count would drop that instruction.

A flush is combined with a push and with resources that would otherwise allow issue. This catches a flush that loses priority to either.

Zero-destination instructions are issued with no rename registers free, to catch a rename test that is off by one.

// File: rtl/iq_dispatch_pkg.sv
package iq_dispatch_pkg;
  localparam int TAG_W     = 8;
  localparam int UNIT_W    = 2;
  localparam int DEST_W    = 2;
  localparam int NUM_UNITS = 1 << UNIT_W;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [UNIT_W-1:0] unit;
    logic [DEST_W-1:0] dests;
  } iqEntry_t;

  // strobes from control to the queue datapath
  typedef struct packed {
    logic [1:0] popCount;
    logic       pushEn;
    logic       clearAll;
  } qCtrl_t;
endpackage

// File: rtl/iq_dispatch_queue.sv
module iq_dispatch_queue import iq_dispatch_pkg::*; #(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  qCtrl_t           ctrl,
  input  iqEntry_t         pushEntry,
  output iqEntry_t         head0,
  output iqEntry_t         head1,
  output logic [CNT_W-1:0] count
);
  iqEntry_t         slotQ [DEPTH];
  iqEntry_t         slotD [DEPTH];
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] keptCount;

  assign keptCount = countQ - CNT_W'(ctrl.popCount);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam int SRC1 = (i + 1 < DEPTH) ? i + 1 : i;
    localparam int SRC2 = (i + 2 < DEPTH) ? i + 2 : i;
    always_comb begin
      case (ctrl.popCount)
        2'd1:    slotD[i] = slotQ[SRC1];
        2'd2:    slotD[i] = slotQ[SRC2];
        default: slotD[i] = slotQ[i];
      endcase
      if (ctrl.pushEn && keptCount == CNT_W'(i)) slotD[i] = pushEntry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      for (int i = 0; i < DEPTH; i++) slotQ[i] <= '0;
    end else begin
      countQ <= ctrl.clearAll ? '0 : keptCount + CNT_W'(ctrl.pushEn);
      for (int i = 0; i < DEPTH; i++) slotQ[i] <= slotD[i];
    end
  end

  assign head0 = slotQ[0];
  assign head1 = slotQ[1];
  assign count = countQ;
endmodule

// File: rtl/iq_dispatch_ctrl.sv
module iq_dispatch_ctrl import iq_dispatch_pkg::*; #(
  parameter int DEPTH = 6,
  parameter int REN_W = 4,
  parameter int CQ_W  = 3,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SUM_W = DEST_W + 1
) (
  input  iqEntry_t             head0,
  input  iqEntry_t             head1,
  input  logic [CNT_W-1:0]     count,
  input  logic [NUM_UNITS-1:0] unitBusy,
  input  logic [REN_W-1:0]     renameFree,
  input  logic [CQ_W-1:0]      cqFree,
  input  logic                 flush,
  input  logic                 pushValid,
  output qCtrl_t               ctrl,
  output logic                 go0,
  output logic                 go1,
  output logic [NUM_UNITS-1:0] dispStrobe,
  output logic [REN_W-1:0]     renameAlloc,
  output logic                 pushAccept
);
  logic [SUM_W-1:0] need0, needBoth;
  logic             have0, have1;
  logic [1:0]       popCount;
  logic [CNT_W-1:0] kept;

  assign need0    = SUM_W'(head0.dests);
  assign needBoth = need0 + SUM_W'(head1.dests);
  assign have0    = count >= CNT_W'(1);
  assign have1    = count >= CNT_W'(2);

  // slot 1 is only considered behind slot 0 (in order), with cumulative resources
  assign go0 = !flush && have0 && !unitBusy[head0.unit]
             && (renameFree >= REN_W'(need0)) && (cqFree >= CQ_W'(1));
  assign go1 = go0 && have1 && (head1.unit != head0.unit) && !unitBusy[head1.unit]
             && (renameFree >= REN_W'(needBoth)) && (cqFree >= CQ_W'(2));

  assign popCount   = 2'(go0) + 2'(go1);
  assign kept       = count - CNT_W'(popCount);
  assign pushAccept = pushValid && !flush && (kept < CNT_W'(DEPTH));

  assign renameAlloc = (go0 ? REN_W'(head0.dests) : '0) + (go1 ? REN_W'(head1.dests) : '0);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_strobe
    assign dispStrobe[u] = (go0 && head0.unit == UNIT_W'(u))
                        || (go1 && head1.unit == UNIT_W'(u));
  end

  assign ctrl.popCount = popCount;
  assign ctrl.pushEn   = pushAccept;
  assign ctrl.clearAll = flush;
endmodule

// File: rtl/iq_dispatch_top.sv
module iq_dispatch_top import iq_dispatch_pkg::*; #(
  parameter int DEPTH = 6,
  parameter int REN_W = 4,
  parameter int CQ_W  = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  logic                 pushValid,
  input  logic [TAG_W-1:0]     pushTag,
  input  logic [UNIT_W-1:0]    pushUnit,
  input  logic [DEST_W-1:0]    pushDests,
  output logic                 pushAccept,
  input  logic [NUM_UNITS-1:0] unitBusy,
  input  logic [REN_W-1:0]     renameFree,
  input  logic [CQ_W-1:0]      cqFree,
  output logic                 dispGo0,
  output logic [TAG_W-1:0]     dispTag0,
  output logic                 dispGo1,
  output logic [TAG_W-1:0]     dispTag1,
  output logic [NUM_UNITS-1:0] dispStrobe,
  output logic [REN_W-1:0]     renameAlloc,
  output logic [1:0]           cqAlloc,
  output logic [CNT_W-1:0]     queueCount
);
  qCtrl_t   ctrl;
  iqEntry_t head0, head1, pushEntry;

  assign pushEntry = '{tag: pushTag, unit: pushUnit, dests: pushDests};

  iq_dispatch_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pushEntry(pushEntry),
    .head0(head0), .head1(head1), .count(queueCount)
  );

  iq_dispatch_ctrl #(.DEPTH(DEPTH), .REN_W(REN_W), .CQ_W(CQ_W)) u_ctrl (
    .head0(head0), .head1(head1), .count(queueCount), .unitBusy(unitBusy),
    .renameFree(renameFree), .cqFree(cqFree), .flush(flush), .pushValid(pushValid),
    .ctrl(ctrl), .go0(dispGo0), .go1(dispGo1), .dispStrobe(dispStrobe),
    .renameAlloc(renameAlloc), .pushAccept(pushAccept)
  );

  assign dispTag0 = head0.tag;
  assign dispTag1 = head1.tag;
  assign cqAlloc  = ctrl.popCount;
endmodule

// File: rtl/iq_dispatch_chk.sv
module iq_dispatch_chk #(
  parameter int NUM_UNITS = 4,
  parameter int DEPTH     = 6,
  parameter int REN_W     = 4,
  parameter int CQ_W      = 3,
  parameter int CNT_W     = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 flush,
  input logic [NUM_UNITS-1:0] unitBusy,
  input logic [REN_W-1:0]     renameFree,
  input logic [CQ_W-1:0]      cqFree,
  input logic                 pushAccept,
  input logic                 dispGo0,
  input logic                 dispGo1,
  input logic [NUM_UNITS-1:0] dispStrobe,
  input logic [REN_W-1:0]     renameAlloc,
  input logic [1:0]           cqAlloc,
  input logic [CNT_W-1:0]     queueCount
);
  a_r2_in_order: assert property (@(posedge clk) disable iff (!rstN)
    dispGo1 |-> dispGo0);
  a_r3_busy_unit_idle: assert property (@(posedge clk) disable iff (!rstN)
    (dispStrobe & unitBusy) == '0);
  a_r4_one_per_unit: assert property (@(posedge clk) disable iff (!rstN)
    $countones(dispStrobe) == int'(cqAlloc));
  a_r5_rename_supply: assert property (@(posedge clk) disable iff (!rstN)
    renameAlloc <= renameFree);
  a_r6_cq_space: assert property (@(posedge clk) disable iff (!rstN)
    CQ_W'(cqAlloc) <= cqFree);
  a_r7_shift_count: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && !pushAccept) |=> queueCount == $past(queueCount) - CNT_W'($past(cqAlloc)));
  a_r8_push_count: assert property (@(posedge clk) disable iff (!rstN)
    pushAccept |=> queueCount == $past(queueCount) - CNT_W'($past(cqAlloc)) + CNT_W'(1));
  a_r8_bounded: assert property (@(posedge clk) disable iff (!rstN)
    queueCount <= CNT_W'(DEPTH));
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> queueCount == '0);
  a_r9_flush_blocks: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (!dispGo0 && !pushAccept));
endmodule

bind iq_dispatch_top iq_dispatch_chk #(
  .NUM_UNITS(iq_dispatch_pkg::NUM_UNITS), .DEPTH(DEPTH), .REN_W(REN_W),
  .CQ_W(CQ_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .unitBusy(unitBusy),
  .renameFree(renameFree), .cqFree(cqFree), .pushAccept(pushAccept),
  .dispGo0(dispGo0), .dispGo1(dispGo1), .dispStrobe(dispStrobe),
  .renameAlloc(renameAlloc), .cqAlloc(cqAlloc), .queueCount(queueCount)
);

// File: tb/iq_dispatch_top_test.sv
`timescale 1ns/1ps
module iq_dispatch_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       flush = 1'b0;
  logic       pushValid = 1'b0;
  logic [7:0] pushTag = '0;
  logic [1:0] pushUnit = '0;
  logic [1:0] pushDests = '0;
  logic [3:0] unitBusy = '0;
  logic [3:0] renameFree = 4'd8;
  logic [2:0] cqFree = '0;
  logic       pushAccept, dispGo0, dispGo1;
  logic [7:0] dispTag0, dispTag1;
  logic [3:0] dispStrobe, renameAlloc;
  logic [1:0] cqAlloc;
  logic [2:0] queueCount;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int expQ[$];

  always #5 clk = ~clk;

  iq_dispatch_top uut (
    .clk(clk), .rstN(rstN), .flush(flush), .pushValid(pushValid), .pushTag(pushTag),
    .pushUnit(pushUnit), .pushDests(pushDests), .pushAccept(pushAccept),
    .unitBusy(unitBusy), .renameFree(renameFree), .cqFree(cqFree),
    .dispGo0(dispGo0), .dispTag0(dispTag0), .dispGo1(dispGo1), .dispTag1(dispTag1),
    .dispStrobe(dispStrobe), .renameAlloc(renameAlloc), .cqAlloc(cqAlloc),
    .queueCount(queueCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // driver side of the scoreboard
  task automatic expectDispatch(input int tag);
    expQ.push_back(tag);
  endtask

  task automatic offer(input bit v, input int tag, input int unit, input int dests);
    pushValid = v;
    pushTag   = 8'(tag);
    pushUnit  = 2'(unit);
    pushDests = 2'(dests);
  endtask

  task automatic nextCycle();
    @(posedge clk);
    #1;
  endtask

  // monitor side: issued tags must match expected order (R2, R7)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (dispGo0) begin
        if (expQ.size() == 0) check(0, "R7 unexpected issue slot0", dispTag0, -1);
        else checkEq("R7 issue order slot0", dispTag0, expQ.pop_front());
      end
      if (dispGo1) begin
        if (expQ.size() == 0) check(0, "R2 unexpected issue slot1", dispTag1, -1);
        else checkEq("R2 issue order slot1", dispTag1, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 reset count", queueCount, 0);
    checkEq("R1 reset go0", dispGo0, 0);
    nextCycle();

    // fill with cqFree = 0, seventh push refused (R8, R6)
    cqFree = 0;
    for (int k = 0; k < 7; k++) begin
      case (k)
        0: offer(1, 1, 0, 1);
        1: offer(1, 2, 0, 1);
        2: offer(1, 3, 1, 2);
        3: offer(1, 4, 2, 0);
        4: offer(1, 5, 3, 1);
        5: offer(1, 6, 1, 1);
        default: offer(1, 99, 0, 0);
      endcase
      @(negedge clk);
      if (k == 6) checkEq("R8 full refuses push", pushAccept, 0);
      if (k < 6) checkEq("R8 push accepted with room", pushAccept, 1);
      nextCycle();
    end
    offer(0, 0, 0, 0);
    @(negedge clk);
    checkEq("R8 count full", queueCount, 6);
    checkEq("R6 no cq space no issue", dispGo0, 0);
    nextCycle();

    // one cq slot: only slot 0 issues
    cqFree = 1; expectDispatch(1);
    @(negedge clk);
    checkEq("R6 single slot go0", dispGo0, 1);
    checkEq("R6 single slot go1", dispGo1, 0);
    checkEq("R6 cqAlloc", cqAlloc, 1);
    checkEq("R10 strobe unit0", dispStrobe, 4'b0001);
    nextCycle();

    // rename covers slot0 only (tags 2 d1, 3 d2, free 2)
    cqFree = 4; renameFree = 2; expectDispatch(2);
    @(negedge clk);
    checkEq("R7 shift by one", queueCount, 5);
    checkEq("R5 cumulative rename blocks slot1", dispGo1, 0);
    checkEq("R5 renameAlloc single", renameAlloc, 1);
    nextCycle();

    // unit 1 busy blocks tag3, and tag4 behind it (R3, R2)
    unitBusy = 4'b0010;
    @(negedge clk);
    checkEq("R7 count 4", queueCount, 4);
    checkEq("R3 busy unit blocks", dispGo0, 0);
    checkEq("R2 slot1 waits for slot0", dispGo1, 0);
    nextCycle();

    unitBusy = 4'b0000; expectDispatch(3); expectDispatch(4);
    @(negedge clk);
    checkEq("R2 both issue", dispGo1, 1);
    checkEq("R5 renameAlloc pair", renameAlloc, 2);
    checkEq("R10 strobes units 1,2", dispStrobe, 4'b0110);
    checkEq("R6 cqAlloc pair", cqAlloc, 2);
    nextCycle();

    cqFree = 0; offer(1, 7, 3, 0);
    @(negedge clk);
    checkEq("R7 shift by two", queueCount, 2);
    nextCycle();
    offer(1, 8, 3, 0);
    nextCycle();

    // issue two and push in same cycle
    cqFree = 4; renameFree = 8; offer(1, 9, 0, 0); expectDispatch(5); expectDispatch(6);
    @(negedge clk);
    checkEq("R8 count before", queueCount, 4);
    checkEq("R8 push with issue", pushAccept, 1);
    nextCycle();

    offer(0, 0, 0, 0); expectDispatch(7);
    @(negedge clk);
    checkEq("R8 count after push+issue", queueCount, 3);
    checkEq("R4 same unit blocks slot1", dispGo1, 0);
    checkEq("R4 strobe unit3 only", dispStrobe, 4'b1000);
    nextCycle();

    expectDispatch(8); expectDispatch(9);
    @(negedge clk);
    checkEq("R4 distinct units pair", dispGo1, 1);
    nextCycle();
    @(negedge clk);
    checkEq("R7 drained", queueCount, 0);
    nextCycle();

    // flush overrides issue and push
    cqFree = 0; offer(1, 10, 0, 0);
    nextCycle();
    offer(1, 11, 1, 0);
    nextCycle();
    flush = 1; cqFree = 4; offer(1, 12, 2, 0);
    @(negedge clk);
    checkEq("R9 flush blocks issue", dispGo0, 0);
    checkEq("R9 flush blocks push", pushAccept, 0);
    nextCycle();
    flush = 0; cqFree = 0; offer(0, 0, 0, 0);
    @(negedge clk);
    checkEq("R9 flush empties", queueCount, 0);
    nextCycle();

    // full queue, issue and push in same cycle; zero dests with no rename
    for (int k = 0; k < 6; k++) begin
      offer(1, 20 + k, k % 4, 0);
      nextCycle();
    end
    cqFree = 1; renameFree = 0; offer(1, 26, 2, 0); expectDispatch(20);
    @(negedge clk);
    checkEq("R8 full accepts when issuing", pushAccept, 1);
    checkEq("R5 zero dests need no rename", dispGo0, 1);
    nextCycle();
    cqFree = 0; offer(0, 0, 0, 0);
    @(negedge clk);
    checkEq("R8 stays full", queueCount, 6);
    nextCycle();
    flush = 1;
    nextCycle();
    flush = 0;
    @(negedge clk);
    checkEq("R9 second flush empties", queueCount, 0);
    checkEq("R7 all expected issues seen", expQ.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule